// File: doc/BRIEF.md
# Programming-Status Read Path

This block sits between a nonvolatile array's read port and the bidirectional data bus. While an internal programming operation is running, it replaces parts of each read result with status information, so that a host can find out when programming has finished by doing ordinary reads. A read of the most recently written location shows that byte's top bit inverted. Every read taken while programming is in progress flips a second status bit. When the busy flag drops, reads return the array contents unchanged.

The programming timer is outside this block and arrives as the `prog_busy` input. The write logic supplies the address and value of the last byte it loaded. A one-cycle `rd_strobe` marks each read cycle, which happens whenever the host toggles output-enable, chip-enable or both. The block also registers the bus drive enable from the three active-low control pins.

Top module: `poll_status_rd`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_data` is 0 and `drive_en` is 0.
- R2: `drive_en` is 1 in the cycle after a clock edge that sampled `ce_n`=0, `oe_n`=0 and `we_n`=1. After any other sampled combination it is 0.
- R3: When `rd_strobe` is sampled high with `prog_busy` low, `rd_data` equals the sampled `array_data` on all 8 bits from the next cycle on. This holds even when `rd_addr` equals `last_addr`.
- R4: When `rd_strobe` is sampled high with `prog_busy` high and `rd_addr` equal to `last_addr`, bit 7 of `rd_data` is the complement of bit 7 of `last_data`.
- R5: Each strobed read taken with `prog_busy` high returns bit 6 inverted relative to bit 6 of the previous busy read. The value of bit 6 on the very first busy read after reset is not defined.
- R6: Reads taken with `prog_busy` low do not advance the bit-6 toggle. The first busy read after an idle interval therefore returns the complement of bit 6 from the last busy read before that interval.
- R7: On a busy read of an address other than `last_addr`, bits 7 and 5..0 of `rd_data` equal `array_data`.
- R8: `rd_data` changes only in the cycle after a sampled `rd_strobe`. Without a strobe it holds its value, even when `array_data` and `prog_busy` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_strobe | input | 1 | One-cycle pulse per read cycle |
| rd_addr | input | 19 | Address of the current read |
| array_data | input | 8 | Array contents at `rd_addr` |
| prog_busy | input | 1 | Internal programming in progress |
| last_addr | input | 19 | Address of the last byte loaded |
| last_data | input | 8 | Value of the last byte loaded |
| rd_data | output | 8 | Read result to the bus |
| drive_en | output | 1 | Tri-state drive enable for the data bus |

## Verification
Reads are issued in four situations: idle with a matching and a non-matching address, busy at the last-written address, busy elsewhere, and busy again after an idle stretch. The idle-match case separates true-data return from polling. The busy-elsewhere case shows that the inversion is tied to the address. The busy-after-idle case shows that the toggle freezes instead of counting every strobe. `last_data` is used with both values of its top bit, so a stuck inversion shows up. All eight combinations of the three control pins that matter are applied to `drive_en`.

// File: rtl/poll_status_pkg.sv
package poll_status_pkg;

    // Per-read control decided from the current inputs
    typedef struct packed {
        logic busy;   // programming in progress
        logic hit;    // read address equals last loaded address
        logic tog;    // current toggle level
    } poll_ctl_t;

    function automatic logic bus_may_drive(input logic ce_n, input logic oe_n, input logic we_n);
        return (!ce_n) && (!oe_n) && we_n;
    endfunction

endpackage

// File: rtl/poll_toggle.sv
module poll_toggle #(
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    output logic tog_o
);
    logic tog_q;

    always_ff @(posedge clk) begin
        if (rst)        tog_q <= INIT;
        else if (adv_i) tog_q <= ~tog_q;
    end

    assign tog_o = tog_q;
endmodule

// File: rtl/poll_compose.sv
module poll_compose
    import poll_status_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  poll_ctl_t          ctl_i,
    input  logic [DATA_W-1:0]  array_i,
    input  logic [DATA_W-1:0]  last_i,
    output logic [DATA_W-1:0]  word_o
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign word_o[i] = (ctl_i.busy && ctl_i.hit) ? ~last_i[i] : array_i[i];
        end else if (i == TOGGLE_BIT) begin : g_tog
            assign word_o[i] = ctl_i.busy ? ctl_i.tog : array_i[i];
        end else begin : g_pass
            assign word_o[i] = array_i[i];
        end
    end
endmodule

// File: rtl/poll_bus_gate.sv
module poll_bus_gate
    import poll_status_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic drive_o
);
    logic drive_q;

    always_ff @(posedge clk) begin
        if (rst) drive_q <= 1'b0;
        else     drive_q <= bus_may_drive(ce_n, oe_n, we_n);
    end

    assign drive_o = drive_q;
endmodule

// File: rtl/poll_status_rd.sv
module poll_status_rd
    import poll_status_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = DATA_W - 1,
    parameter int TOGGLE_BIT = DATA_W - 2,
    parameter bit TOG_INIT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    input  logic              prog_busy,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              drive_en
);
    localparam logic [DATA_W-1:0] ZERO_WORD = '0;

    poll_ctl_t         ctl;
    logic              tog;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] rd_q;

    poll_toggle #(.INIT(TOG_INIT)) u_tog (
        .clk   (clk),
        .rst   (rst),
        .adv_i (rd_strobe && prog_busy),
        .tog_o (tog)
    );

    always_comb begin
        ctl.busy = prog_busy;
        ctl.hit  = (rd_addr == last_addr);
        ctl.tog  = tog;
    end

    poll_compose #(
        .DATA_W     (DATA_W),
        .POLL_BIT   (POLL_BIT),
        .TOGGLE_BIT (TOGGLE_BIT)
    ) u_comp (
        .ctl_i   (ctl),
        .array_i (array_data),
        .last_i  (last_data),
        .word_o  (word)
    );

    always_ff @(posedge clk) begin
        if (rst)            rd_q <= ZERO_WORD;
        else if (rd_strobe) rd_q <= word;
    end

    poll_bus_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .drive_o (drive_en)
    );

    assign rd_data = rd_q;
endmodule

// File: rtl/poll_status_rd_chk.sv
module poll_status_rd_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              rd_strobe,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] array_data,
    input logic              prog_busy,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              drive_en
);
    // Reference for bit 6 of the previous busy read, kept by the checker
    logic pend, have_prev, prev_b6, past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            have_prev <= 1'b0;
            prev_b6   <= 1'b0;
            past_ok   <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            pend    <= rd_strobe && prog_busy;
            if (pend) begin
                have_prev <= 1'b1;
                prev_b6   <= rd_data[6];
            end
        end
    end

    assert_drive_R2: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (drive_en == $past(!ce_n && !oe_n && we_n)));

    assert_true_data_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !prog_busy) |=> (rd_data == $past(array_data)));

    assert_poll_inv_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && prog_busy && rd_addr == last_addr) |=> (rd_data[7] == !$past(last_data[7])));

    // Covers R5 and R6: the reference survives idle reads
    assert_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && prog_busy && have_prev && !pend) |=> (rd_data[6] != prev_b6));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(rd_data));
endmodule

bind poll_status_rd poll_status_rd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/poll_status_rd_test.sv
module poll_status_rd_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic        rd_strobe = 1'b0;
    logic [18:0] rd_addr = '0;
    logic [7:0]  array_data = '0;
    logic        prog_busy = 1'b0;
    logic [18:0] last_addr = '0;
    logic [7:0]  last_data = '0;
    logic [7:0]  rd_data;
    logic        drive_en;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        bit         tog;
        string      tag;
    } item_t;

    item_t q[$];
    event  sample_ev;
    bit    tog_known = 0;
    logic  tog_ref = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    poll_status_rd uut (.*);

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares with the design output
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                if (it.mask != 8'h00)
                    check((rd_data & it.mask) == (it.exp & it.mask), it.tag, rd_data & it.mask, it.exp & it.mask);
                if (it.tog) begin
                    if (tog_known)
                        check(rd_data[6] == !tog_ref, it.tag, {7'b0, rd_data[6]}, {7'b0, !tog_ref});
                    tog_ref   = rd_data[6];
                    tog_known = 1;
                end
            end
        end
    end

    // Driver: one strobed read, expectation pushed to the scoreboard
    task automatic do_read(input logic [18:0] a, input logic [7:0] arr,
                           input logic [7:0] exp, input logic [7:0] mask,
                           input bit tg, input string tag);
        item_t it;
        @(negedge clk);
        rd_addr = a; array_data = arr; rd_strobe = 1'b1;
        it.exp = exp; it.mask = mask; it.tog = tg; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        rd_strobe = 1'b0;
        array_data = ~arr;
        -> sample_ev;
        #1;
    endtask

    task automatic pins(input logic c, input logic o, input logic w, input logic exp);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w;
        @(negedge clk);
        check(drive_en == exp, "R2 drive_en", {7'b0, drive_en}, {7'b0, exp});
    endtask

    initial begin
        #(PERIOD * 20000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_data == 8'h00, "R1 rd_data in reset", rd_data, 8'h00);
        check(drive_en == 1'b0, "R1 drive_en in reset", {7'b0, drive_en}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 8'h00);
        check(drive_en == 1'b0, "R1 drive_en after reset", {7'b0, drive_en}, 8'h00);

        // R2: every control combination
        for (int k = 0; k < 8; k++)
            pins(k[2], k[1], k[0], (k[2:0] == 3'b001));
        pins(1'b1, 1'b1, 1'b1, 1'b0);

        // R3: idle reads, including the last-written address
        last_addr = 19'h05555; last_data = 8'hC5;
        do_read(19'h00010, 8'h5A, 8'h5A, 8'hFF, 0, "R3 idle read");
        do_read(19'h05555, 8'hC5, 8'hC5, 8'hFF, 0, "R3 idle read at last addr");
        do_read(19'h7FFFF, 8'hFF, 8'hFF, 8'hFF, 0, "R3 idle read all ones");

        // Busy interval one
        @(negedge clk); prog_busy = 1'b1;
        do_read(19'h05555, 8'h3A, 8'h00, 8'h80, 1, "R4 poll inv bit7 (last=C5)");
        do_read(19'h05555, 8'h3A, 8'h00, 8'h80, 1, "R5 toggle on busy read");
        do_read(19'h00123, 8'h81, 8'h81, 8'hBF, 1, "R7 other addr passthrough");
        do_read(19'h00124, 8'h2E, 8'h2E, 8'hBF, 1, "R7 other addr passthrough b");
        do_read(19'h05555, 8'h00, 8'h00, 8'h80, 1, "R5 toggle again");

        // R8: hold without strobe
        begin
            logic [7:0] held;
            held = rd_data;
            @(negedge clk); array_data = 8'hA5; prog_busy = 1'b0;
            repeat (3) @(negedge clk);
            check(rd_data == held, "R8 hold without strobe", rd_data, held);
            prog_busy = 1'b1;
        end
        @(negedge clk); prog_busy = 1'b0;

        // Idle reads do not advance toggle
        do_read(19'h05555, 8'hC5, 8'hC5, 8'hFF, 0, "R3 true data after busy");
        do_read(19'h00001, 8'h40, 8'h40, 8'hFF, 0, "R3 idle bit6 set");
        do_read(19'h00002, 8'h00, 8'h00, 8'hFF, 0, "R3 idle zero");

        // Busy interval two, last byte with bit7 clear
        last_addr = 19'h02AAA; last_data = 8'h12;
        @(negedge clk); prog_busy = 1'b1;
        do_read(19'h02AAA, 8'h12, 8'h80, 8'h80, 1, "R6 toggle frozen across idle, R4 inv of 0");
        do_read(19'h02AAA, 8'h12, 8'h80, 8'h80, 1, "R5 toggle interval two");
        do_read(19'h05555, 8'h7F, 8'h7F, 8'hBF, 1, "R7 old last addr not polled");
        @(negedge clk); prog_busy = 1'b0;
        do_read(19'h02AAA, 8'h12, 8'h12, 8'hFF, 0, "R3 true data at end");

        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule